// File: doc/BRIEF.md
# ADC Injected Conversion Sequencer

This block sequences the priority ("injected") conversion group of a successive-approximation converter. Four rank slots each carry a channel number, a sample time in converter clocks and an offset. When a start condition is seen, the block walks the configured ranks in ascending order. For each rank it sends one start pulse to the converter, together with the channel number and the total conversion time. It then waits for the converter's done pulse and stores the raw value minus the rank's offset as a signed result in that rank's data register.

A sequence can be started in three ways: by a software start pulse, by an edge on one of the selectable external trigger lines, or automatically when the regular conversion group reports that it has finished. Scan mode converts the whole configured length; without scan, only the first rank is converted. Discontinuous mode converts one rank per trigger. A one-cycle end-of-sequence pulse marks the point where the final rank's result becomes visible. The converter itself lives outside the block, behind the start/done handshake.

Top module: `adc_inj_seq`

## Requirements
- R1: After reset, `eos` and `convStart` are low, every field of `rankData` is zero, and the software start mode is selected.
- R2: `seqLen` is legal only from 1 to 4. With `scanEn` high, one trigger converts ranks 0 to `seqLen`-1 in ascending order, with exactly one `convStart` per rank. With `seqLen` set to 0 or to a value above 4, triggers start nothing.
- R3: With `scanEn` low, a trigger converts rank 0 only and raises `eos` after it, whatever `seqLen` holds.
- R4: With `scanEn` and `discEn` high and `contEn` low, each trigger converts exactly one rank, and the rank pointer advances by one per trigger. `eos` fires only after the last rank, and the following trigger begins again at rank 0. With `contEn` high, `discEn` is ignored and one trigger converts the whole sequence.
- R5: With `autoEn` high, `discEn` low and software start mode selected, a `regDone` pulse starts the sequence. When `discEn` is high or an external source is selected, `regDone` starts nothing.
- R6: `trigEdge` selects the external edge that starts a sequence: 00 none, 01 rising, 10 falling, 11 both.
- R7: The trigger source written through `cfgTrigSrc` takes values 0 to 10 or 15, each selecting `extTrig` line of the same index. Values 11 to 14 select no line. Writing `cfgSwMode`=1 selects software start and disables all external lines. In external mode, `swStart` is ignored.
- R8: A `cfgWr` pulse while `adcEnable` is high changes neither the trigger mode nor the trigger source.
- R9: Each rank's 13-bit result in `rankData` (rank k in bits [13k+12:13k]) equals the raw value minus that rank's offset in two's complement. When the raw value is below the offset, the result is negative.
- R10: `resSel` selects the resolution: 00 gives 12 bits, 01 gives 10, 10 gives 8 and 11 gives 6. Raw and offset bits above the resolution are ignored.
- R11: `convCycles` equals the rank's sample time plus 12, 11, 9 or 7 clocks for `resSel` 00, 01, 10 or 11.
- R12: `eos` is a one-cycle pulse. It is high in the cycle when the last rank's new result first appears, which is one cycle after the `convDone` that completes that rank.
- R13: A trigger that arrives while a conversion is in flight is ignored. This includes a trigger during a discontinuous step and one in the cycle the last `convDone` is accepted.
- R14: `convStart` is a one-cycle pulse, and `convChan` carries the current rank's channel. While `adcEnable` is low, triggers are ignored and the rank pointer returns to rank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| adcEnable | input | 1 | Converter enabled; locks the trigger configuration |
| cfgWr | input | 1 | Write strobe for trigger mode and source |
| cfgSwMode | input | 1 | Value to write: 1 selects software start |
| cfgTrigSrc | input | 4 | Value to write: external trigger line index |
| trigEdge | input | 2 | External edge sensitivity |
| extTrig | input | 16 | External trigger lines |
| swStart | input | 1 | Software start pulse |
| regDone | input | 1 | Regular group finished pulse |
| scanEn | input | 1 | Scan mode |
| discEn | input | 1 | Discontinuous mode |
| contEn | input | 1 | Continuous mode (disables discontinuous) |
| autoEn | input | 1 | Start after regular group |
| seqLen | input | 3 | Sequence length, 1 to 4 |
| resSel | input | 2 | Resolution select |
| rankChan | input | 20 | Four 5-bit channel numbers, rank 0 in the low bits |
| rankSmp | input | 36 | Four 9-bit sample times |
| rankOfs | input | 48 | Four 12-bit offsets |
| convStart | output | 1 | Conversion request pulse |
| convChan | output | 5 | Channel to convert |
| convCycles | output | 10 | Total conversion time in clocks |
| convDone | input | 1 | Conversion finished pulse |
| convRaw | input | 12 | Raw conversion value, valid with `convDone` |
| rankData | output | 52 | Four 13-bit signed results |
| eos | output | 1 | End of sequence pulse |

## Verification
Two events can land on the same clock edge: the completion of the last rank, which writes its result, raises `eos` and returns the control to idle, and a fresh start trigger. The converter model in the bench can raise `swStart` in exactly the cycle it returns `convDone` for the final rank. The run is judged by counting start pulses: a correct block ignores that trigger, so no extra `convStart` appears, and the queued `eos` and result checks still hold. The same start counting judges triggers fired in the middle of a discontinuous step.

// File: rtl/adc_inj_pkg.sv
package adc_inj_pkg;

  localparam int MAX_RANKS = 4;
  localparam int RANK_W    = $clog2(MAX_RANKS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BUSY  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              wr;
    logic [RANK_W-1:0] rank;
  } dpStrobe_t;

  // processing clocks added to the sample time, per resolution code
  function automatic logic [3:0] procCycles(input logic [1:0] res);
    case (res)
      2'd0:    return 4'd12;
      2'd1:    return 4'd11;
      2'd2:    return 4'd9;
      default: return 4'd7;
    endcase
  endfunction

endpackage

// File: rtl/adc_inj_ctrl.sv
module adc_inj_ctrl
  import adc_inj_pkg::*;
#(
  parameter int TRIG_N      = 16,
  parameter int SEL_W       = 4,
  parameter int LEN_W       = 3,
  parameter int SRC_LOW_MAX = 10,
  parameter int SRC_ALT     = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adcEnable,
  input  logic             cfgWr,
  input  logic             cfgSwMode,
  input  logic [SEL_W-1:0] cfgTrigSrc,
  input  logic [1:0]       trigEdge,
  input  logic [TRIG_N-1:0] extTrig,
  input  logic             swStart,
  input  logic             regDone,
  input  logic             scanEn,
  input  logic             discEn,
  input  logic             contEn,
  input  logic             autoEn,
  input  logic [LEN_W-1:0] seqLen,
  input  logic             convDone,
  output logic             convStart,
  output logic             eos,
  output dpStrobe_t        strb
);

  seqState_t         state;
  logic [RANK_W-1:0] ptr;
  logic              swMode;
  logic [SEL_W-1:0]  trigSrc;
  logic [TRIG_N-1:0] prevTrig;

  // trigger configuration, frozen while the converter is enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swMode  <= 1'b1;
      trigSrc <= '0;
    end else if (cfgWr && !adcEnable) begin
      swMode  <= cfgSwMode;
      trigSrc <= cfgTrigSrc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTrig <= '0;
    else       prevTrig <= extTrig;
  end

  logic curLine, oldLine, srcValid, extEdge;
  logic discEff, autoEff, lenOk, trigHit, go, isLast;
  logic [RANK_W-1:0] lastIdx;

  always_comb begin
    curLine  = extTrig[trigSrc];
    oldLine  = prevTrig[trigSrc];
    srcValid = (trigSrc <= SEL_W'(SRC_LOW_MAX)) || (trigSrc == SEL_W'(SRC_ALT));
    extEdge  = srcValid && ((trigEdge[0] && curLine && !oldLine) ||
                            (trigEdge[1] && !curLine && oldLine));
    discEff  = discEn && scanEn && !contEn;
    autoEff  = autoEn && swMode && !discEn;
    lenOk    = (seqLen != '0) && (seqLen <= LEN_W'(MAX_RANKS));
    lastIdx  = scanEn ? RANK_W'(seqLen - 1'b1) : '0;
    trigHit  = swMode ? (swStart || (autoEff && regDone)) : extEdge;
    go       = (state == ST_IDLE) && adcEnable && lenOk && trigHit;
    isLast   = (ptr >= lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ptr   <= '0;
      eos   <= 1'b0;
    end else begin
      eos <= 1'b0;
      if (!adcEnable) begin
        state <= ST_IDLE;
        ptr   <= '0;
      end else begin
        case (state)
          ST_IDLE:  if (go) state <= ST_START;
          ST_START: state <= ST_BUSY;
          ST_BUSY: begin
            if (convDone) begin
              if (isLast) begin
                eos   <= 1'b1;
                ptr   <= '0;
                state <= ST_IDLE;
              end else begin
                ptr   <= ptr + 1'b1;
                state <= discEff ? ST_IDLE : ST_START;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign convStart = (state == ST_START);
  assign strb.wr   = (state == ST_BUSY) && convDone && adcEnable;
  assign strb.rank = ptr;

  // R12: end-of-sequence never lasts two cycles
  p_eos_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    eos |=> !eos);

  // R14: conversion request is a single-cycle pulse
  p_start_single_r14: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R8: trigger configuration cannot move while enabled
  p_src_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(adcEnable) |-> ($stable(trigSrc) && $stable(swMode)));

  // R13: a new request only follows idle or a completed rank
  p_start_from_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStart) |-> ($past(state) != ST_BUSY || $past(convDone)));

endmodule

// File: rtl/adc_inj_dp.sv
module adc_inj_dp
  import adc_inj_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int SMP_W  = 9,
  parameter int RAW_W  = 12,
  localparam int CYC_W = SMP_W + 1,
  localparam int RES_W = RAW_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strb,
  input  logic [1:0]                  resSel,
  input  logic [MAX_RANKS*CHAN_W-1:0] rankChan,
  input  logic [MAX_RANKS*SMP_W-1:0]  rankSmp,
  input  logic [MAX_RANKS*RAW_W-1:0]  rankOfs,
  input  logic [RAW_W-1:0]            convRaw,
  output logic [CHAN_W-1:0]           convChan,
  output logic [CYC_W-1:0]            convCycles,
  output logic [MAX_RANKS*RES_W-1:0]  rankData
);

  logic [CHAN_W-1:0] chanArr [MAX_RANKS];
  logic [SMP_W-1:0]  smpArr  [MAX_RANKS];
  logic [RAW_W-1:0]  ofsArr  [MAX_RANKS];

  logic [RAW_W-1:0] resMask, rawM, ofsM;
  logic [RES_W-1:0] diffVal;

  always_comb begin
    resMask    = {RAW_W{1'b1}} >> (2 * resSel);
    rawM       = convRaw & resMask;
    ofsM       = ofsArr[strb.rank] & resMask;
    diffVal    = {1'b0, rawM} - {1'b0, ofsM};
    convChan   = chanArr[strb.rank];
    convCycles = CYC_W'(smpArr[strb.rank]) + CYC_W'(procCycles(resSel));
  end

  for (genvar g = 0; g < MAX_RANKS; g++) begin : g_rank
    logic [RES_W-1:0] dataReg;

    assign chanArr[g] = rankChan[g*CHAN_W +: CHAN_W];
    assign smpArr[g]  = rankSmp[g*SMP_W +: SMP_W];
    assign ofsArr[g]  = rankOfs[g*RAW_W +: RAW_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        dataReg <= '0;
      else if (strb.wr && strb.rank == RANK_W'(g))      dataReg <= diffVal;
    end

    assign rankData[g*RES_W +: RES_W] = dataReg;
  end

  // R9: results move only on a write strobe
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr |=> $stable(rankData));

endmodule

// File: rtl/adc_inj_seq.sv
module adc_inj_seq
  import adc_inj_pkg::*;
#(
  parameter int TRIG_N = 16,
  parameter int SEL_W  = 4,
  parameter int LEN_W  = 3,
  parameter int CHAN_W = 5,
  parameter int SMP_W  = 9,
  parameter int RAW_W  = 12,
  localparam int CYC_W = SMP_W + 1,
  localparam int RES_W = RAW_W + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        adcEnable,
  input  logic                        cfgWr,
  input  logic                        cfgSwMode,
  input  logic [SEL_W-1:0]            cfgTrigSrc,
  input  logic [1:0]                  trigEdge,
  input  logic [TRIG_N-1:0]           extTrig,
  input  logic                        swStart,
  input  logic                        regDone,
  input  logic                        scanEn,
  input  logic                        discEn,
  input  logic                        contEn,
  input  logic                        autoEn,
  input  logic [LEN_W-1:0]            seqLen,
  input  logic [1:0]                  resSel,
  input  logic [MAX_RANKS*CHAN_W-1:0] rankChan,
  input  logic [MAX_RANKS*SMP_W-1:0]  rankSmp,
  input  logic [MAX_RANKS*RAW_W-1:0]  rankOfs,
  output logic                        convStart,
  output logic [CHAN_W-1:0]           convChan,
  output logic [CYC_W-1:0]            convCycles,
  input  logic                        convDone,
  input  logic [RAW_W-1:0]            convRaw,
  output logic [MAX_RANKS*RES_W-1:0]  rankData,
  output logic                        eos
);

  dpStrobe_t dpStrb;

  adc_inj_ctrl #(
    .TRIG_N(TRIG_N), .SEL_W(SEL_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .adcEnable(adcEnable),
    .cfgWr(cfgWr), .cfgSwMode(cfgSwMode), .cfgTrigSrc(cfgTrigSrc),
    .trigEdge(trigEdge), .extTrig(extTrig), .swStart(swStart),
    .regDone(regDone), .scanEn(scanEn), .discEn(discEn),
    .contEn(contEn), .autoEn(autoEn), .seqLen(seqLen),
    .convDone(convDone), .convStart(convStart), .eos(eos), .strb(dpStrb)
  );

  adc_inj_dp #(
    .CHAN_W(CHAN_W), .SMP_W(SMP_W), .RAW_W(RAW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(dpStrb), .resSel(resSel),
    .rankChan(rankChan), .rankSmp(rankSmp), .rankOfs(rankOfs),
    .convRaw(convRaw), .convChan(convChan), .convCycles(convCycles),
    .rankData(rankData)
  );

  // R12: end of sequence only right after a result write
  p_eos_after_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    eos |-> $past(dpStrb.wr));

endmodule

// File: tb/adc_inj_seq_tb.sv
module adc_inj_seq_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, adcEnable, cfgWr, cfgSwMode, swStart, regDone;
  logic scanEn, discEn, contEn, autoEn, convDone;
  logic [3:0]  cfgTrigSrc;
  logic [1:0]  trigEdge, resSel;
  logic [15:0] extTrig;
  logic [2:0]  seqLen;
  logic [19:0] rankChan;
  logic [35:0] rankSmp;
  logic [47:0] rankOfs;
  logic [11:0] convRaw;
  logic        convStart, eos;
  logic [4:0]  convChan;
  logic [9:0]  convCycles;
  logic [51:0] rankData;

  logic [4:0]  chanCfg [4];
  logic [8:0]  smpCfg  [4];
  logic [11:0] ofsCfg  [4];
  logic [11:0] rawSeed;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rankChan[i*5 +: 5]   = chanCfg[i];
      rankSmp[i*9 +: 9]    = smpCfg[i];
      rankOfs[i*12 +: 12]  = ofsCfg[i];
    end
  end

  adc_inj_seq u_dut (
    .clk(clk), .rstN(rstN), .adcEnable(adcEnable), .cfgWr(cfgWr),
    .cfgSwMode(cfgSwMode), .cfgTrigSrc(cfgTrigSrc), .trigEdge(trigEdge),
    .extTrig(extTrig), .swStart(swStart), .regDone(regDone),
    .scanEn(scanEn), .discEn(discEn), .contEn(contEn), .autoEn(autoEn),
    .seqLen(seqLen), .resSel(resSel), .rankChan(rankChan),
    .rankSmp(rankSmp), .rankOfs(rankOfs), .convStart(convStart),
    .convChan(convChan), .convCycles(convCycles), .convDone(convDone),
    .convRaw(convRaw), .rankData(rankData), .eos(eos)
  );

  typedef struct {
    logic [4:0]  chan;
    logic [9:0]  cyc;
    int          rank;
    logic [11:0] raw;
    logic [12:0] data;
    bit          lastEos;
    string       req;
  } item_t;

  item_t expQ[$];
  int nChecks = 0, nFail = 0, starts = 0, base = 0;
  bit monBusy = 1'b0, collideSw = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] rawFor(logic [4:0] ch);
    return 12'(int'(ch) * 163 + int'(rawSeed));
  endfunction

  function automatic logic [12:0] expData(logic [11:0] raw, logic [11:0] ofs, logic [1:0] res);
    logic [11:0] m;
    m = 12'hFFF >> (2 * res);
    return {1'b0, raw & m} - {1'b0, ofs & m};
  endfunction

  function automatic logic [3:0] procOf(logic [1:0] res);
    return (res == 2'd0) ? 4'd12 : (res == 2'd1) ? 4'd11 : (res == 2'd2) ? 4'd9 : 4'd7;
  endfunction

  // driver side of the scoreboard
  task automatic expectSeq(int first, int count, bit endEos, string req);
    for (int r = first; r < first + count; r++) begin
      item_t it;
      it.chan    = chanCfg[r];
      it.cyc     = 10'(smpCfg[r]) + 10'(procOf(resSel));
      it.rank    = r;
      it.raw     = rawFor(chanCfg[r]);
      it.data    = expData(it.raw, ofsCfg[r], resSel);
      it.lastEos = endEos && (r == first + count - 1);
      it.req     = req;
      expQ.push_back(it);
    end
  endtask

  // converter model and monitor
  task automatic serve();
    item_t it;
    monBusy = 1'b1;
    starts++;
    if (expQ.size() == 0) begin
      check(1'b0, "R13", "unexpected convStart chan", longint'(convChan), 0);
      it.chan = convChan; it.cyc = 10'd3; it.rank = 0; it.raw = 12'd0;
      it.data = 13'd0; it.lastEos = 1'b0; it.req = "R13";
      repeat (3) @(negedge clk);
      convDone = 1'b1;
      @(negedge clk);
      convDone = 1'b0;
    end else begin
      it = expQ.pop_front();
      check(convChan == it.chan, "R14", {it.req, " channel"}, longint'(convChan), longint'(it.chan));
      check(convCycles == it.cyc, "R11", {it.req, " cycles"}, longint'(convCycles), longint'(it.cyc));
      convRaw = it.raw;
      repeat (int'(it.cyc)) @(negedge clk);
      convDone = 1'b1;
      if (collideSw && it.lastEos) swStart = 1'b1;
      @(negedge clk);
      convDone = 1'b0;
      swStart  = 1'b0;
      check(rankData[it.rank*13 +: 13] == it.data, "R9", {it.req, " result"},
            longint'(rankData[it.rank*13 +: 13]), longint'(it.data));
      check(eos == it.lastEos, "R12", {it.req, " eos"}, longint'(eos), longint'(it.lastEos));
    end
    monBusy = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (convStart) serve();
    end
  end

  task automatic drain();
    repeat (4) @(negedge clk);
    while (expQ.size() != 0 || monBusy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseSw();
    @(negedge clk); swStart = 1'b1;
    @(negedge clk); swStart = 1'b0;
  endtask

  task automatic pulseReg();
    @(negedge clk); regDone = 1'b1;
    @(negedge clk); regDone = 1'b0;
  endtask

  task automatic writeCfg(bit sw, logic [3:0] src);
    @(negedge clk); cfgWr = 1'b1; cfgSwMode = sw; cfgTrigSrc = src;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic setLine(int idx, bit v);
    @(negedge clk); extTrig[idx] = v;
  endtask

  task automatic markBase();
    base = starts;
  endtask

  task automatic checkStarts(int exp, string req, string what);
    check((starts - base) == exp, req, what, longint'(starts - base), longint'(exp));
  endtask

  task automatic reEnable();
    @(negedge clk); adcEnable = 1'b0;
    @(negedge clk); adcEnable = 1'b1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    rstN = 1'b0; adcEnable = 1'b0; cfgWr = 1'b0; cfgSwMode = 1'b1; cfgTrigSrc = 4'd0;
    trigEdge = 2'b00; extTrig = '0; swStart = 1'b0; regDone = 1'b0;
    scanEn = 1'b0; discEn = 1'b0; contEn = 1'b0; autoEn = 1'b0;
    seqLen = 3'd4; resSel = 2'd0; convDone = 1'b0; convRaw = '0; rawSeed = 12'h2A5;
    chanCfg[0] = 5'd3;  chanCfg[1] = 5'd8;  chanCfg[2] = 5'd13; chanCfg[3] = 5'd21;
    smpCfg[0]  = 9'd4;  smpCfg[1]  = 9'd9;  smpCfg[2]  = 9'd16; smpCfg[3]  = 9'd24;
    ofsCfg[0]  = 12'h010; ofsCfg[1] = 12'h100; ofsCfg[2] = 12'h800; ofsCfg[3] = 12'hFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(eos == 1'b0, "R1", "eos after reset", longint'(eos), 0);
    check(convStart == 1'b0, "R1", "convStart after reset", longint'(convStart), 0);
    check(rankData == '0, "R1", "rankData after reset", longint'(rankData[31:0]), 0);

    // R14 triggers ignored while disabled
    markBase(); pulseSw(); drain();
    checkStarts(0, "R14", "start while disabled");

    // R2 full scan sequence, software start (R1 default mode)
    adcEnable = 1'b1; scanEn = 1'b1;
    markBase(); expectSeq(0, 4, 1'b1, "R2"); pulseSw(); drain();
    checkStarts(4, "R2", "ranks in full scan");

    // R2 illegal lengths
    seqLen = 3'd0; markBase(); pulseSw(); drain();
    checkStarts(0, "R2", "length 0");
    seqLen = 3'd5; markBase(); pulseSw(); drain();
    checkStarts(0, "R2", "length 5");

    // R3 scan off converts rank 0 only
    seqLen = 3'd4; scanEn = 1'b0; rawSeed = 12'h013;
    markBase(); expectSeq(0, 1, 1'b1, "R3"); pulseSw(); drain();
    checkStarts(1, "R3", "scan off");

    // R4 discontinuous stepping
    scanEn = 1'b1; discEn = 1'b1; seqLen = 3'd3;
    for (int r = 0; r < 3; r++) begin
      markBase(); expectSeq(r, 1, r == 2, "R4"); pulseSw(); drain();
      checkStarts(1, "R4", "one rank per trigger");
    end
    markBase(); expectSeq(0, 1, 1'b0, "R4"); pulseSw(); drain();
    checkStarts(1, "R4", "wrap to rank 0");
    reEnable();
    contEn = 1'b1;
    markBase(); expectSeq(0, 3, 1'b1, "R4"); pulseSw(); drain();
    checkStarts(3, "R4", "continuous overrides discontinuous");
    contEn = 1'b0;

    // R13 trigger during a discontinuous step
    reEnable(); seqLen = 3'd2;
    markBase(); expectSeq(0, 1, 1'b0, "R13"); pulseSw();
    repeat (3) @(negedge clk); pulseSw(); drain();
    checkStarts(1, "R13", "trigger in disc step");
    markBase(); expectSeq(1, 1, 1'b1, "R13"); pulseSw(); drain();
    checkStarts(1, "R13", "next step after ignored trigger");

    // R13 trigger mid sequence and in the completing cycle
    discEn = 1'b0; seqLen = 3'd4; collideSw = 1'b1;
    markBase(); expectSeq(0, 4, 1'b1, "R13"); pulseSw();
    repeat (5) @(negedge clk); pulseSw(); drain();
    checkStarts(4, "R13", "triggers while busy");
    collideSw = 1'b0;

    // R5 auto start after regular group
    autoEn = 1'b1; seqLen = 3'd2;
    markBase(); expectSeq(0, 2, 1'b1, "R5"); pulseReg(); drain();
    checkStarts(2, "R5", "auto start");
    discEn = 1'b1; markBase(); pulseReg(); drain();
    checkStarts(0, "R5", "auto blocked by disc");
    discEn = 1'b0;

    // external triggers
    adcEnable = 1'b0; writeCfg(1'b0, 4'd5); adcEnable = 1'b1;
    scanEn = 1'b0; trigEdge = 2'b01;
    markBase(); pulseReg(); pulseSw(); drain();
    checkStarts(0, "R5", "regDone and swStart in external mode (R7)");
    autoEn = 1'b0;
    markBase(); expectSeq(0, 1, 1'b1, "R6"); setLine(5, 1'b1); drain();
    checkStarts(1, "R6", "rising edge");
    markBase(); setLine(5, 1'b0); drain();
    checkStarts(0, "R6", "falling ignored when rising selected");
    markBase(); setLine(4, 1'b1); setLine(4, 1'b0); drain();
    checkStarts(0, "R7", "unselected line");
    trigEdge = 2'b10;
    markBase(); setLine(5, 1'b1); drain();
    checkStarts(0, "R6", "rising ignored when falling selected");
    markBase(); expectSeq(0, 1, 1'b1, "R6"); setLine(5, 1'b0); drain();
    checkStarts(1, "R6", "falling edge");
    trigEdge = 2'b00;
    markBase(); setLine(5, 1'b1); setLine(5, 1'b0); drain();
    checkStarts(0, "R6", "edge none");
    trigEdge = 2'b11;
    markBase(); expectSeq(0, 1, 1'b1, "R6"); setLine(5, 1'b1); drain();
    expectSeq(0, 1, 1'b1, "R6"); setLine(5, 1'b0); drain();
    checkStarts(2, "R6", "both edges");

    // R7 alternate and invalid sources
    trigEdge = 2'b01;
    adcEnable = 1'b0; writeCfg(1'b0, 4'd15); adcEnable = 1'b1;
    markBase(); expectSeq(0, 1, 1'b1, "R7"); setLine(15, 1'b1); drain();
    checkStarts(1, "R7", "source 15");
    setLine(15, 1'b0);
    adcEnable = 1'b0; writeCfg(1'b0, 4'd12); adcEnable = 1'b1;
    markBase(); setLine(12, 1'b1); setLine(12, 1'b0); drain();
    checkStarts(0, "R7", "source 12 selects nothing");

    // R8 write while enabled is ignored
    writeCfg(1'b1, 4'd0);
    markBase(); pulseSw(); drain();
    checkStarts(0, "R8", "mode write while enabled");
    markBase(); setLine(12, 1'b1); setLine(12, 1'b0); drain();
    checkStarts(0, "R8", "source kept after locked write");

    // R10 resolution masking, R9 negative result
    adcEnable = 1'b0; writeCfg(1'b1, 4'd0); adcEnable = 1'b1;
    scanEn = 1'b1; seqLen = 3'd4;
    for (int res = 1; res < 4; res++) begin
      resSel = 2'(res); rawSeed = 12'(12'hC37 + res * 12'h155);
      markBase(); expectSeq(0, 4, 1'b1, "R10"); pulseSw(); drain();
      checkStarts(4, "R10", "resolution run");
    end
    resSel = 2'd0; rawSeed = 12'h001; ofsCfg[0] = 12'hFFF;
    expectSeq(0, 1, 1'b0, "R9"); expectSeq(1, 3, 1'b1, "R9"); pulseSw(); drain();
    check(rankData[12] == 1'b1, "R9", "negative sign bit rank 0", longint'(rankData[12]), 1);

    finishRun();
  end

endmodule